// File: doc/BRIEF.md
# Rotate, Shift and Bit-Manipulation Execution Unit

This is a purely combinational execution unit for the bit-manipulation instruction class of an 8-bit processor. The surrounding core decodes the prefix and fetches the operand byte. That byte may come from a register or from memory. The core then presents three things: the 8-bit extended opcode, the operand, and the current flag byte. Within the same cycle the unit returns the result byte, the new flag byte, a write-enable and a 3-bit destination select that tells the core where the result goes.

The opcode's top two bits pick one of four groups: rotate/shift, bit test, bit clear and bit set. The middle three bits name either a rotate/shift kind or a bit number. The low three bits name the operand location. There are eight rotate/shift kinds, which include the shift-left variant that inserts a one. Bit test only produces flags. Bit clear and bit set modify the byte and pass the flags through untouched.

Top module: `rsb_unit`

## Requirements
- R1: `wr_en_o` is 0 when opcode[7:6] = 01 (bit test) and 1 for 00 (rotate/shift), 10 (bit clear) and 11 (bit set).
- R2: `dst_sel_o` equals opcode[2:0], with 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 memory at the HL address, 7 A; code 6 means the result is written back to memory.
- R3: With opcode[5:3] = 0 (left circular), bit 7 of the operand goes to both result bit 0 and carry. With opcode[5:3] = 1 (right circular), bit 0 goes to both result bit 7 and carry.
- R4: With opcode[5:3] = 2, the unit rotates left through the carry: flags_i[0] enters bit 0 and operand bit 7 becomes the carry. With opcode[5:3] = 3, it rotates right through the carry: flags_i[0] enters bit 7 and operand bit 0 becomes the carry.
- R5: Each shift kind moves the bit it shifts out into carry:
  - 4, arithmetic left: inserts 0 at bit 0.
  - 5, arithmetic right: keeps bit 7.
  - 6, left with one inserted: inserts 1 at bit 0.
  - 7, logical right: inserts 0 at bit 7.
- R6: For rotate/shift, the flag byte is laid out as bit 7 S, 6 Z, 5 unused, 4 H, 3 unused, 2 P/V, 1 N, 0 C. S is result bit 7. Z is set when the result is zero. P/V is set when the result has an even number of ones. H, N and the two unused bits are 0.
- R7: For bit test on bit n = opcode[5:3]:
  - Z and P/V are the inverse of operand bit n.
  - S is set only when n = 7 and the tested bit is 1.
  - H is 1.
  - N and the two unused bits are 0.
  - C keeps flags_i[0].
- R8: For bit test, `result_o` equals the operand unchanged.
- R9: Bit clear sets operand bit n = opcode[5:3] to 0 and leaves every other bit as it was; `flags_o` equals `flags_i`.
- R10: Bit set sets operand bit n = opcode[5:3] to 1 and leaves every other bit as it was; `flags_o` equals `flags_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 8 | Extended opcode byte |
| operand_i | input | 8 | Operand byte, already fetched |
| flags_i | input | 8 | Current flag byte; bit 0 is carry |
| result_o | output | 8 | Result byte |
| flags_o | output | 8 | Updated flag byte |
| wr_en_o | output | 1 | Result is to be written to the destination |
| dst_sel_o | output | 3 | Destination select; 6 selects memory |

## Verification
The checker evaluates several properties continuously, whatever the inputs happen to be:
- the write-enable is off for bit test;
- bit clear and bit set pass the flags through and touch only the addressed bit;
- bit test sets H and keeps carry;
- for every rotate/shift, S, Z, H and N agree with the result.

Three things can only be shown by the bench's sweep, which compares every output against a separately computed model:
- the exact data movement of each of the eight rotate/shift kinds, including the carry taken in and the carry pushed out;
- the parity flag;
- the destination mapping.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned IDX_W  = $clog2(DATA_W);
  localparam int unsigned SEL_W  = 3;

  // flag byte positions
  localparam int unsigned FL_C = 0;
  localparam int unsigned FL_N = 1;
  localparam int unsigned FL_P = 2;
  localparam int unsigned FL_H = 4;
  localparam int unsigned FL_Z = 6;
  localparam int unsigned FL_S = 7;

  typedef enum logic [1:0] {
    GRP_SHIFT = 2'b00,
    GRP_TEST  = 2'b01,
    GRP_CLEAR = 2'b10,
    GRP_FORCE = 2'b11
  } grp_e;

  typedef enum logic [2:0] {
    SH_ROL_CIRC = 3'd0,
    SH_ROR_CIRC = 3'd1,
    SH_ROL_THRU = 3'd2,
    SH_ROR_THRU = 3'd3,
    SH_LEFT_0   = 3'd4,
    SH_RIGHT_AR = 3'd5,
    SH_LEFT_1   = 3'd6,
    SH_RIGHT_LG = 3'd7
  } shift_e;
endpackage

// File: rtl/rsb_decode.sv
module rsb_decode
  import rsb_pkg::*;
(
  input  logic [DATA_W-1:0] opcode_i,
  output grp_e              grp_o,
  output shift_e            kind_o,
  output logic [IDX_W-1:0]  bit_idx_o,
  output logic [SEL_W-1:0]  sel_o
);
  assign grp_o     = grp_e'(opcode_i[7:6]);
  assign kind_o    = shift_e'(opcode_i[5:3]);
  assign bit_idx_o = opcode_i[5:3];
  assign sel_o     = opcode_i[2:0];
endmodule

// File: rtl/rsb_shifter.sv
module rsb_shifter
  import rsb_pkg::*;
(
  input  shift_e            kind_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic [DATA_W-1:0] flags_o
);
  logic go_left;
  logic fill;
  logic cout;

  always_comb begin
    go_left = 1'b0;
    fill    = 1'b0;
    unique case (kind_i)
      SH_ROL_CIRC: begin go_left = 1'b1; fill = operand_i[DATA_W-1]; end
      SH_ROR_CIRC: fill = operand_i[0];
      SH_ROL_THRU: begin go_left = 1'b1; fill = carry_i; end
      SH_ROR_THRU: fill = carry_i;
      SH_LEFT_0:   go_left = 1'b1;
      SH_RIGHT_AR: fill = operand_i[DATA_W-1];
      SH_LEFT_1:   begin go_left = 1'b1; fill = 1'b1; end
      SH_RIGHT_LG: fill = 1'b0;
      default:     fill = 1'b0;
    endcase
  end

  // one shared left/right datapath; the kind only chooses the incoming bit
  assign result_o = go_left ? {operand_i[DATA_W-2:0], fill}
                            : {fill, operand_i[DATA_W-1:1]};
  assign cout     = go_left ? operand_i[DATA_W-1] : operand_i[0];

  always_comb begin
    flags_o       = '0;
    flags_o[FL_S] = result_o[DATA_W-1];
    flags_o[FL_Z] = (result_o == '0);
    flags_o[FL_P] = ~(^result_o);
    flags_o[FL_C] = cout;
  end
endmodule

// File: rtl/rsb_bitop.sv
module rsb_bitop
  import rsb_pkg::*;
(
  input  grp_e              grp_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [DATA_W-1:0] flags_i,
  output logic [DATA_W-1:0] result_o,
  output logic [DATA_W-1:0] flags_o
);
  logic [DATA_W-1:0] mask;
  logic              tested;

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign mask[g] = (bit_idx_i == IDX_W'(g));
  end

  assign tested = |(operand_i & mask);

  always_comb begin
    result_o = operand_i;
    flags_o  = flags_i;
    unique case (grp_i)
      GRP_CLEAR: result_o = operand_i & ~mask;
      GRP_FORCE: result_o = operand_i | mask;
      GRP_TEST: begin
        flags_o       = '0;
        flags_o[FL_S] = tested & mask[DATA_W-1];
        flags_o[FL_Z] = ~tested;
        flags_o[FL_P] = ~tested;
        flags_o[FL_H] = 1'b1;
        flags_o[FL_C] = flags_i[FL_C];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
  import rsb_pkg::*;
(
  input  logic [7:0] opcode_i,
  input  logic [7:0] operand_i,
  input  logic [7:0] flags_i,
  output logic [7:0] result_o,
  output logic [7:0] flags_o,
  output logic       wr_en_o,
  output logic [2:0] dst_sel_o
);
  grp_e              grp;
  shift_e            kind;
  logic [IDX_W-1:0]  bit_idx;
  logic [DATA_W-1:0] sh_res, sh_flg, bo_res, bo_flg;

  rsb_decode u_dec (
    .opcode_i  (opcode_i),
    .grp_o     (grp),
    .kind_o    (kind),
    .bit_idx_o (bit_idx),
    .sel_o     (dst_sel_o)
  );

  rsb_shifter u_sh (
    .kind_i    (kind),
    .operand_i (operand_i),
    .carry_i   (flags_i[FL_C]),
    .result_o  (sh_res),
    .flags_o   (sh_flg)
  );

  rsb_bitop u_bo (
    .grp_i     (grp),
    .bit_idx_i (bit_idx),
    .operand_i (operand_i),
    .flags_i   (flags_i),
    .result_o  (bo_res),
    .flags_o   (bo_flg)
  );

  always_comb begin
    if (grp == GRP_SHIFT) begin
      result_o = sh_res;
      flags_o  = sh_flg;
    end else begin
      result_o = bo_res;
      flags_o  = bo_flg;
    end
  end

  assign wr_en_o = (grp != GRP_TEST);
endmodule

// File: rtl/rsb_unit_chk.sv
module rsb_unit_chk (
  input logic [7:0] opcode_i,
  input logic [7:0] operand_i,
  input logic [7:0] flags_i,
  input logic [7:0] result_o,
  input logic [7:0] flags_o,
  input logic       wr_en_o,
  input logic [2:0] dst_sel_o
);
  logic [7:0] m;
  assign m = 8'd1 << opcode_i[5:3];

  always_comb begin
    if (opcode_i[7:6] == 2'b01) begin
      assert_test_no_write_R1: assert (!wr_en_o) else $error("R1 write on bit test");
      assert_test_flags_R7: assert (flags_o[4] && !flags_o[1] && flags_o[0] == flags_i[0])
        else $error("R7 bit test flags");
      assert_test_passthru_R8: assert (result_o == operand_i) else $error("R8 operand altered");
    end
    if (opcode_i[7:6] == 2'b10) begin
      assert_clear_R9: assert (((result_o & m) == 8'h00) && ((result_o | m) == (operand_i | m))
                               && flags_o == flags_i) else $error("R9 bit clear");
    end
    if (opcode_i[7:6] == 2'b11) begin
      assert_force_R10: assert (((result_o & m) == m) && ((result_o & ~m) == (operand_i & ~m))
                                && flags_o == flags_i) else $error("R10 bit set");
    end
    if (opcode_i[7:6] == 2'b00) begin
      assert_shift_flags_R6: assert (flags_o[7] == result_o[7] && flags_o[6] == (result_o == 8'h00)
                                     && !flags_o[4] && !flags_o[1]) else $error("R6 shift flags");
    end
  end
endmodule

bind rsb_unit rsb_unit_chk u_chk (.*);

// File: tb/rsb_unit_tb_top.sv
module rsb_unit_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] opcode, operand, flags_in;
  logic [7:0] result, flags_out;
  logic       wr_en;
  logic [2:0] dst_sel;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  rsb_unit dut_i (
    .opcode_i  (opcode),
    .operand_i (operand),
    .flags_i   (flags_in),
    .result_o  (result),
    .flags_o   (flags_out),
    .wr_en_o   (wr_en),
    .dst_sel_o (dst_sel)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s op=%02h opd=%02h fl=%02h act=%0h exp=%0h", req, opcode, operand, flags_in, act, exp);
    end
  endtask

  function automatic int popc(logic [7:0] v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic check_vec();
    int grp  = int'(opcode) / 64;
    int mid  = (int'(opcode) / 8) % 8;
    int opd  = int'(operand);
    int cin  = int'(flags_in) % 2;
    int bitv = (opd >> mid) % 2;
    int eres, efl, ins, cout;
    string rtag;
    check("R2", int'(dst_sel), int'(opcode) % 8);
    check("R1", int'(wr_en), (grp == 1) ? 0 : 1);
    case (grp)
      0: begin
        case (mid)
          0: ins = opd / 128;
          1: ins = opd % 2;
          2, 3: ins = cin;
          5: ins = opd / 128;
          6: ins = 1;
          default: ins = 0;
        endcase
        if (mid % 2 == 0 && mid != 6 || mid == 6) begin
          eres = ((opd * 2) % 256) + ins;
          cout = opd / 128;
        end else begin
          eres = (opd / 2) + ins * 128;
          cout = opd % 2;
        end
        rtag = (mid < 2) ? "R3" : (mid < 4) ? "R4" : "R5";
        efl = (eres / 128) * 128 + ((eres == 0) ? 64 : 0)
            + ((popc(8'(eres)) % 2 == 0) ? 4 : 0) + cout;
        check(rtag, int'(result), eres);
        check("R6", int'(flags_out), efl);
      end
      1: begin
        efl = 16 + cin + ((bitv == 0) ? 64 + 4 : 0) + ((mid == 7 && bitv == 1) ? 128 : 0);
        check("R8", int'(result), opd);
        check("R7", int'(flags_out), efl);
      end
      2: begin
        check("R9", int'(result), opd - bitv * (1 << mid));
        check("R9", int'(flags_out), int'(flags_in));
      end
      default: begin
        check("R10", int'(result), opd + (1 - bitv) * (1 << mid));
        check("R10", int'(flags_out), int'(flags_in));
      end
    endcase
  endtask

  initial begin : watchdog
    while (cycles < 190000) begin
      @(posedge clk);
      cycles++;
    end
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : stim
    opcode = 8'h00; operand = 8'h00; flags_in = 8'h00;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // idle state: left circular on zero gives zero result, Z and even parity
    check("R6", int'(flags_out), 8'h44);
    check("R3", int'(result), 0);
    for (int op = 0; op < 256; op++) begin
      for (int d = 0; d < 256; d++) begin
        @(posedge clk);
        opcode   = 8'(op);
        operand  = 8'(d);
        // vary the carry and the other flag bits with the vector
        flags_in = 8'(d ^ 8'h5A ^ op);
        @(negedge clk);
        check_vec();
      end
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule